// File: doc/BRIEF.md
# Access Fault Status Word Generator

This block records why and where the last memory access fault happened. A fault is signalled either by the address translation walker or by the bus logic when an access hits no mapped target. On the clock edge where either strobe is high, the block stores two things. The first is a 16-bit status word, whose bits describe the access size, the transfer mode and the direction. The second is the faulting address. On that same edge it raises a one-cycle exception request toward the core sequencer.

The exception sequencer later pushes the status word and the address into a fault stack frame. For that reason the bit layout of the status word is fixed. The two fault kinds update the word differently. A translation fault builds a new word from zero. A bus fault merges into the word already held: it rewrites only the size and mode fields, sets the fault bit, and sets the direction bit for reads. Software reads both registers through a small read port, and the port cannot change them.

Top module: `fault_status_capture`

## Requirements
- R1: After reset the status word is 0x0000, the stored address is 0, and the exception request is low.
- R2: When `xlat_fault_i` is high at a clock edge, the status word becomes a new word. It has bit 10 set, plus the size, mode and direction fields below, and every other bit is zero.
- R3: The access size sits in status bits 6:5. The input code for `acc_size_i` is 0 for byte, 1 for word, 2 for long and 3 for a full line. These give field values 0x20, 0x40, 0x00 and 0x60 respectively.
- R4: The transfer mode sits in status bits 2:0. A data access gives 0x1 and a code fetch gives 0x2. A supervisor access (`acc_super_i`=1) also adds 0x4.
- R5: On a translation fault, bit 8 is 1 for a read (`acc_write_i`=0) and 0 for a write.
- R6: When `bus_fault_i` is high at an edge and `xlat_fault_i` is low, the block sets bit 10 and replaces bits 6:5 and 2:0 with the new size and mode. It sets bit 8 for a read. All other bits keep their previous value, and this includes bit 8 on a write.
- R7: On an edge with either fault strobe high, the stored address takes `fault_addr_i`.
- R8: `exc_req_o` is high for exactly the one cycle after an edge that captured a fault. On an edge with no strobe, the status word and the address keep their values.
- R9: If both strobes are high on the same edge, the translation-fault treatment (R2) applies.
- R10: `rd_data_o` shows the zero-extended status word when `rd_sel_i`=0 and the stored address when `rd_sel_i`=1. This is combinational, and reading has no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_fault_i | input | 1 | Translation fault strobe |
| bus_fault_i | input | 1 | Unmapped bus access fault strobe |
| fault_addr_i | input | ADDR_W | Address of the faulting access |
| acc_size_i | input | 2 | Size code: 0 byte, 1 word, 2 long, 3 line |
| acc_write_i | input | 1 | 1 for write, 0 for read |
| acc_super_i | input | 1 | Supervisor access |
| acc_code_i | input | 1 | 1 for code fetch, 0 for data |
| rd_sel_i | input | 1 | Read select: 0 status word, 1 address |
| rd_data_o | output | RD_W | Register read data |
| status_word_o | output | SW_W | Stored status word |
| fault_addr_o | output | ADDR_W | Stored fault address |
| exc_req_o | output | 1 | One-cycle exception request |

## Verification
The assertions assume that the size code and the flags are valid whenever a strobe is high. They also assume that no input is unknown after reset. They place no limit on how far apart faults come, so back-to-back strobes and coincident strobes are both legal. The random stimulus draws every input from its full range in every cycle and raises each strobe with moderate probability, so it stays within those assumptions while producing runs of consecutive faults, mixed fault kinds and idle gaps.

// File: rtl/afsw_pkg.sv
package afsw_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_LINE = 2'd3
   } acc_size_e;

   // Field positions are consumed by the fault frame builder: keep fixed.
   localparam int unsigned XLAT_BIT = 10;
   localparam int unsigned DIR_BIT  = 8;
   localparam int unsigned SIZE_LSB = 5;
   localparam int unsigned SIZE_W   = 2;
   localparam int unsigned MODE_LSB = 0;
   localparam int unsigned MODE_W   = 3;
   localparam int unsigned MIN_SW_W = XLAT_BIT + 1;

   localparam logic [SIZE_W-1:0] SZF_BYTE = 2'b01;
   localparam logic [SIZE_W-1:0] SZF_WORD = 2'b10;
   localparam logic [SIZE_W-1:0] SZF_LONG = 2'b00;
   localparam logic [SIZE_W-1:0] SZF_LINE = 2'b11;

   localparam logic [MODE_W-1:0] MODE_DATA  = 3'b001;
   localparam logic [MODE_W-1:0] MODE_CODE  = 3'b010;
   localparam logic [MODE_W-1:0] MODE_SUPER = 3'b100;

   typedef struct packed {
      logic [SIZE_W-1:0] size_f;
      logic [MODE_W-1:0] mode_f;
      logic              is_read;
   } fault_fields_t;

   function automatic logic [SIZE_W-1:0] size_field(acc_size_e s);
      logic [SIZE_W-1:0] f;
      case (s)
         SZ_BYTE: f = SZF_BYTE;
         SZ_WORD: f = SZF_WORD;
         SZ_LONG: f = SZF_LONG;
         default: f = SZF_LINE;
      endcase
      return f;
   endfunction

endpackage

// File: rtl/afsw_field_enc.sv
module afsw_field_enc
   import afsw_pkg::*;
(
   input  logic [1:0]    size_i,
   input  logic          write_i,
   input  logic          super_i,
   input  logic          code_i,
   output fault_fields_t fields_o
);

   always_comb begin
      fields_o.size_f  = size_field(acc_size_e'(size_i));
      fields_o.mode_f  = (code_i ? MODE_CODE : MODE_DATA)
                       | (super_i ? MODE_SUPER : '0);
      fields_o.is_read = ~write_i;
   end

endmodule

// File: rtl/afsw_word_build.sv
module afsw_word_build
   import afsw_pkg::*;
#(
   parameter int unsigned SW_W = 16
) (
   input  logic [SW_W-1:0] cur_sw_i,
   input  fault_fields_t   fields_i,
   input  logic            xlat_i,
   input  logic            bus_i,
   output logic [SW_W-1:0] next_sw_o,
   output logic            load_o
);

   logic [SW_W-1:0] fresh_word;
   logic [SW_W-1:0] merged_word;

   // Translation fault: word rebuilt from zero.
   always_comb begin
      fresh_word                        = '0;
      fresh_word[XLAT_BIT]              = 1'b1;
      fresh_word[DIR_BIT]               = fields_i.is_read;
      fresh_word[SIZE_LSB +: SIZE_W]    = fields_i.size_f;
      fresh_word[MODE_LSB +: MODE_W]    = fields_i.mode_f;
   end

   // Bus fault: merge into held word; direction only ever set.
   always_comb begin
      merged_word                       = cur_sw_i;
      merged_word[XLAT_BIT]             = 1'b1;
      merged_word[SIZE_LSB +: SIZE_W]   = fields_i.size_f;
      merged_word[MODE_LSB +: MODE_W]   = fields_i.mode_f;
      if (fields_i.is_read) begin
         merged_word[DIR_BIT] = 1'b1;
      end
   end

   // Translation fault takes precedence over a coincident bus fault.
   assign next_sw_o = xlat_i ? fresh_word : merged_word;
   assign load_o    = xlat_i | bus_i;

endmodule

// File: rtl/afsw_capture_regs.sv
module afsw_capture_regs #(
   parameter int unsigned SW_W   = 16,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [SW_W-1:0]   next_sw_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [SW_W-1:0]   sw_q_o,
   output logic [ADDR_W-1:0] addr_q_o,
   output logic              pulse_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw_q_o   <= '0;
         addr_q_o <= '0;
         pulse_o  <= 1'b0;
      end else begin
         pulse_o <= load_i;
         if (load_i) begin
            sw_q_o   <= next_sw_i;
            addr_q_o <= addr_i;
         end
      end
   end

endmodule

// File: rtl/afsw_read_mux.sv
module afsw_read_mux #(
   parameter int unsigned SW_W   = 16,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned RD_W   = 32
) (
   input  logic              sel_i,
   input  logic [SW_W-1:0]   sw_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [RD_W-1:0]   data_o
);

   logic [RD_W-1:0] sw_ext;
   logic [RD_W-1:0] addr_ext;

   generate
      if (RD_W > SW_W) begin : g_sw_pad
         assign sw_ext = {{(RD_W-SW_W){1'b0}}, sw_i};
      end else begin : g_sw_exact
         assign sw_ext = sw_i;
      end
      if (RD_W > ADDR_W) begin : g_addr_pad
         assign addr_ext = {{(RD_W-ADDR_W){1'b0}}, addr_i};
      end else begin : g_addr_exact
         assign addr_ext = addr_i;
      end
   endgenerate

   assign data_o = sel_i ? addr_ext : sw_ext;

endmodule

// File: rtl/fault_status_capture.sv
module fault_status_capture
   import afsw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SW_W   = 16,
   parameter int unsigned RD_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xlat_fault_i,
   input  logic              bus_fault_i,
   input  logic [ADDR_W-1:0] fault_addr_i,
   input  logic [1:0]        acc_size_i,
   input  logic              acc_write_i,
   input  logic              acc_super_i,
   input  logic              acc_code_i,
   input  logic              rd_sel_i,
   output logic [RD_W-1:0]   rd_data_o,
   output logic [SW_W-1:0]   status_word_o,
   output logic [ADDR_W-1:0] fault_addr_o,
   output logic              exc_req_o
);

   generate
      if (SW_W < MIN_SW_W) begin : g_bad_sw_w
         $error("SW_W too narrow for the fault bit");
      end
      if (RD_W < ADDR_W || RD_W < SW_W) begin : g_bad_rd_w
         $error("RD_W must cover both registers");
      end
   endgenerate

   fault_fields_t   fields;
   logic [SW_W-1:0] next_sw;
   logic            load;

   afsw_field_enc u_enc (
      .size_i   (acc_size_i),
      .write_i  (acc_write_i),
      .super_i  (acc_super_i),
      .code_i   (acc_code_i),
      .fields_o (fields)
   );

   afsw_word_build #(.SW_W(SW_W)) u_build (
      .cur_sw_i  (status_word_o),
      .fields_i  (fields),
      .xlat_i    (xlat_fault_i),
      .bus_i     (bus_fault_i),
      .next_sw_o (next_sw),
      .load_o    (load)
   );

   afsw_capture_regs #(.SW_W(SW_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .next_sw_i (next_sw),
      .addr_i    (fault_addr_i),
      .sw_q_o    (status_word_o),
      .addr_q_o  (fault_addr_o),
      .pulse_o   (exc_req_o)
   );

   afsw_read_mux #(.SW_W(SW_W), .ADDR_W(ADDR_W), .RD_W(RD_W)) u_rd (
      .sel_i  (rd_sel_i),
      .sw_i   (status_word_o),
      .addr_i (fault_addr_o),
      .data_o (rd_data_o)
   );

endmodule

// File: rtl/afsw_checker.sv
module afsw_checker
   import afsw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SW_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xlat_fault_i,
   input logic              bus_fault_i,
   input logic [ADDR_W-1:0] fault_addr_i,
   input logic              acc_write_i,
   input logic [SW_W-1:0]   status_word_o,
   input logic [ADDR_W-1:0] fault_addr_o,
   input logic              exc_req_o
);

   assert_pulse_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xlat_fault_i || bus_fault_i) |=> exc_req_o);

   assert_no_pulse_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(xlat_fault_i || bus_fault_i) |=> (!exc_req_o && $stable(status_word_o)
                                          && $stable(fault_addr_o)));

   assert_addr_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xlat_fault_i || bus_fault_i) |=> fault_addr_o == $past(fault_addr_i));

   assert_fresh_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_fault_i |=> (status_word_o[XLAT_BIT] &&
                        $countones(status_word_o) ==
                        $countones(status_word_o[SIZE_LSB +: SIZE_W]) +
                        $countones(status_word_o[MODE_LSB +: MODE_W]) + 1 +
                        (status_word_o[DIR_BIT] ? 1 : 0)));

   assert_xlat_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_fault_i |=> status_word_o[DIR_BIT] == !$past(acc_write_i));

   assert_mode_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xlat_fault_i || bus_fault_i) |=> $countones(status_word_o[1:0]) == 1);

   assert_bus_keep_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_fault_i && !xlat_fault_i && acc_write_i) |=>
         (status_word_o[DIR_BIT] == $past(status_word_o[DIR_BIT]) &&
          status_word_o[XLAT_BIT]));

endmodule

bind fault_status_capture afsw_checker #(.ADDR_W(ADDR_W), .SW_W(SW_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .xlat_fault_i  (xlat_fault_i),
   .bus_fault_i   (bus_fault_i),
   .fault_addr_i  (fault_addr_i),
   .acc_write_i   (acc_write_i),
   .status_word_o (status_word_o),
   .fault_addr_o  (fault_addr_o),
   .exc_req_o     (exc_req_o)
);

// File: tb/fault_status_capture_test.sv
module fault_status_capture_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        xlat, bus;
   logic [31:0] addr;
   logic [1:0]  size;
   logic        wr, sup, code, rd_sel;
   logic [31:0] rd_data;
   logic [15:0] sw;
   logic [31:0] fa;
   logic        exc;

   int checks = 0;
   int fails  = 0;
   logic [15:0] m_sw   = 16'h0;
   logic [31:0] m_addr = 32'h0;
   logic        m_exc  = 1'b0;
   logic        m_sel  = 1'b0;

   always #2 clk = ~clk;  // 4 ns period

   fault_status_capture uut (
      .clk(clk), .rst_n(rst_n), .xlat_fault_i(xlat), .bus_fault_i(bus),
      .fault_addr_i(addr), .acc_size_i(size), .acc_write_i(wr),
      .acc_super_i(sup), .acc_code_i(code), .rd_sel_i(rd_sel),
      .rd_data_o(rd_data), .status_word_o(sw), .fault_addr_o(fa),
      .exc_req_o(exc)
   );

   function automatic logic [15:0] model(input logic [15:0] old, input logic x,
      input logic b, input logic [1:0] sz, input logic w, input logic s,
      input logic c);
      logic [15:0] szb, md, dir;
      szb = (sz == 2'd0) ? 16'h0020 : (sz == 2'd1) ? 16'h0040 :
            (sz == 2'd2) ? 16'h0000 : 16'h0060;            // R3
      md  = (c ? 16'h0002 : 16'h0001) | (s ? 16'h0004 : 16'h0000); // R4
      dir = w ? 16'h0000 : 16'h0100;
      if (x) return 16'h0400 | szb | md | dir;              // R2 R5 R9
      if (b) return ((old | 16'h0400) & ~16'h0067) | szb | md | dir; // R6
      return old;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " status word"}, {16'h0, sw}, {16'h0, m_sw});
      chk({tag, " R7 address"}, fa, m_addr);
      chk({tag, " R8 exc_req"}, {31'h0, exc}, {31'h0, m_exc});
      chk({tag, " R10 read port"}, rd_data, m_sel ? m_addr : {16'h0, m_sw});
   endtask

   // Called at a falling edge; drives, then checks at the next falling edge.
   task automatic step(input logic x, input logic b, input logic [31:0] a,
      input logic [1:0] sz, input logic w, input logic s, input logic c,
      input logic sel, input string tag);
      xlat = x; bus = b; addr = a; size = sz; wr = w; sup = s; code = c;
      rd_sel = sel;
      m_sw  = model(m_sw, x, b, sz, w, s, c);
      if (x || b) m_addr = a;
      m_exc = x || b;
      m_sel = sel;
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0001));
      rst_n = 1'b0;
      xlat = 0; bus = 0; addr = 32'hFFFF_FFFF; size = 2'd3; wr = 0;
      sup = 1; code = 1; rd_sel = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      xlat = 0; bus = 0;
      #1;
      check_all("R1 reset");
      @(negedge clk);
      // Directed corner cases
      step(1, 0, 32'h1000_0004, 2'd0, 0, 0, 0, 0, "R2 R3 R4 R5 xlat byte read");
      step(0, 0, 32'hDEAD_BEEF, 2'd2, 1, 1, 1, 1, "R8 idle hold");
      step(0, 1, 32'h2000_0010, 2'd1, 1, 1, 1, 0, "R6 bus write keeps dir");
      step(1, 0, 32'h3000_0020, 2'd2, 1, 1, 0, 1, "R2 R5 xlat long write");
      step(0, 1, 32'h4000_0030, 2'd3, 0, 0, 1, 0, "R3 R6 bus line read");
      step(1, 1, 32'h5000_0040, 2'd1, 1, 0, 0, 1, "R9 both strobes");
      step(0, 1, 32'h6000_0050, 2'd0, 0, 1, 0, 0, "R4 R6 bus super data");
      step(0, 0, 32'h0BAD_F00D, 2'd1, 0, 0, 0, 1, "R10 R8 read no effect");
      step(0, 0, 32'h0BAD_F00D, 2'd1, 0, 0, 0, 0, "R10 read no effect");
      // Constrained random
      for (int i = 0; i < 400; i++) begin
         logic x, b;
         x = ($urandom % 4) == 0;
         b = ($urandom % 3) == 0;
         step(x, b, $urandom, 2'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), "R2 R6 R7 R8 random");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule